// File: doc/BRIEF.md
# Cascaded Magnitude Comparator With Minimum/Maximum Select

This block compares two unsigned operands and reports whether the first is greater than, equal to or less than the second. It is built from identical 4-bit comparator slices joined in a ripple chain. Each slice settles its own pair of nibbles and passes a three-way relation upward. A more significant slice overrides what it receives whenever its own nibbles differ. The slice at the bottom of the chain is seeded with "equal". With the default parameters, three slices cover 12-bit operands.

The greater-than result from the top of the chain also steers a 2:1 selector. One control input picks whether the selector returns the smaller or the larger operand. The whole path is combinational. Nothing is registered and there is no reset inside the block.

Top module: `cmp12_minmax_sel`

## Requirements
- R1: `a_eq_o` is 1 exactly when `opa_i` equals `opb_i`.
- R2: `a_gt_o` is 1 exactly when `opa_i` is greater than `opb_i`, both read as unsigned numbers.
- R3: `a_lt_o` is 1 exactly when `opa_i` is less than `opb_i`, both read as unsigned numbers.
- R4: For every input pair, exactly one of `a_gt_o`, `a_eq_o` and `a_lt_o` is 1.
- R5: When `pick_min_i` is 1, `res_o` equals the smaller of the two operands.
- R6: When `pick_min_i` is 0, `res_o` equals the larger of the two operands.
- R7: When the operands are equal, `res_o` equals `opa_i` in both selector modes.
- R8: The relation is set by the most significant differing bit. A difference in a higher 4-bit slice (bits 11:8 over 7:4 over 3:0) decides the result whatever the lower slices hold. A difference in bit 0 alone is still resolved correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 12 | First unsigned operand |
| opb_i | input | 12 | Second unsigned operand |
| pick_min_i | input | 1 | 1 returns the minimum, 0 returns the maximum |
| res_o | output | 12 | Selected operand |
| a_gt_o | output | 1 | First operand is greater |
| a_eq_o | output | 1 | Operands are equal |
| a_lt_o | output | 1 | First operand is less |

## Verification
The relation flags and the selected result are produced in the same evaluation, from the same chain output. Every vector therefore judges both at once: the flags are checked against a behavioural compare, and the result is checked against a behavioural minimum or maximum for the applied mode. The bench provokes the cases where the two could disagree. These are equal operands in both modes, operands differing only in bit 0, and pairs where an upper slice and a lower slice point in opposite directions. It then runs random pairs under both selector values.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int unsigned SLICE_W    = 4;
    localparam int unsigned NUM_SLICES = 3;
    localparam int unsigned OPER_W     = SLICE_W * NUM_SLICES;

    // three-way relation carried between slices
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    // value fed into the least significant slice
    localparam rel_t REL_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

    // merge a local relation with the one arriving from below
    function automatic rel_t rel_merge(input rel_t local_r, input rel_t below_r);
        rel_t r;
        r.gt = local_r.gt | (local_r.eq & below_r.gt);
        r.eq = local_r.eq & below_r.eq;
        r.lt = local_r.lt | (local_r.eq & below_r.lt);
        return r;
    endfunction

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int unsigned W = SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  rel_t         rel_in,
    output rel_t         rel_out
);

    rel_t local_r;

    // scan from the top bit: the first unequal pair decides
    always_comb begin
        logic decided;
        local_r  = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
        decided  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!decided && (a[i] != b[i])) begin
                decided    = 1'b1;
                local_r.eq = 1'b0;
                local_r.gt = a[i];
                local_r.lt = b[i];
            end
        end
    end

    assign rel_out = rel_merge(local_r, rel_in);

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int unsigned SW = SLICE_W,
    parameter int unsigned NS = NUM_SLICES,
    localparam int unsigned W = SW * NS
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output rel_t         rel
);

    rel_t link [NS+1];

    assign link[0] = REL_SEED;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        cmp_slice #(.W(SW)) u_slice (
            .a       (a[s*SW +: SW]),
            .b       (b[s*SW +: SW]),
            .rel_in  (link[s]),
            .rel_out (link[s+1])
        );
    end

    assign rel = link[NS];

endmodule

// File: rtl/minmax_mux.sv
module minmax_mux #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_greater,
    input  logic         pick_min,
    output logic [W-1:0] res
);

    // take b when it is the wanted extreme, otherwise a
    always_comb begin
        if (pick_min) res = a_greater ? b : a;
        else          res = a_greater ? a : b;
    end

endmodule

// File: rtl/cmp12_minmax_sel.sv
module cmp12_minmax_sel
    import cmp_pkg::*;
#(
    parameter int unsigned SW = SLICE_W,
    parameter int unsigned NS = NUM_SLICES,
    localparam int unsigned W = SW * NS
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         pick_min_i,
    output logic [W-1:0] res_o,
    output logic         a_gt_o,
    output logic         a_eq_o,
    output logic         a_lt_o
);

    rel_t rel;

    cmp_chain #(.SW(SW), .NS(NS)) u_chain (
        .a   (opa_i),
        .b   (opb_i),
        .rel (rel)
    );

    minmax_mux #(.W(W)) u_mux (
        .a         (opa_i),
        .b         (opb_i),
        .a_greater (rel.gt),
        .pick_min  (pick_min_i),
        .res       (res_o)
    );

    assign a_gt_o = rel.gt;
    assign a_eq_o = rel.eq;
    assign a_lt_o = rel.lt;

endmodule

// File: rtl/cmp12_minmax_chk.sv
module cmp12_minmax_chk #(
    parameter int unsigned W = 12
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         pick_min_i,
    input logic [W-1:0] res_o,
    input logic         a_gt_o,
    input logic         a_eq_o,
    input logic         a_lt_o
);

    always_comb begin
        assert_eq_flag_R1:   assert (a_eq_o == (opa_i == opb_i));
        assert_gt_flag_R2:   assert (a_gt_o == (opa_i > opb_i));
        assert_lt_flag_R3:   assert (a_lt_o == (opa_i < opb_i));
        assert_one_flag_R4:  assert ($onehot({a_gt_o, a_eq_o, a_lt_o}));
        assert_min_sel_R5:   assert (!pick_min_i || (res_o <= opa_i && res_o <= opb_i));
        assert_max_sel_R6:   assert (pick_min_i || (res_o >= opa_i && res_o >= opb_i));
        assert_eq_res_R7:    assert (!(opa_i == opb_i) || res_o == opa_i);
    end

endmodule

bind cmp12_minmax_sel cmp12_minmax_chk #(.W(W)) u_chk (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .pick_min_i (pick_min_i),
    .res_o      (res_o),
    .a_gt_o     (a_gt_o),
    .a_eq_o     (a_eq_o),
    .a_lt_o     (a_lt_o)
);

// File: tb/sim_cmp12_minmax_sel.sv
module sim_cmp12_minmax_sel;

    localparam int unsigned W       = 12;
    localparam time         CLK_PER = 10ns;
    localparam int unsigned N_RAND  = 300;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         pmin;
        logic [W-1:0] res;
        logic         gt, eq, lt;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0, opb = '0;
    logic         pmin = 1'b0;
    logic [W-1:0] res;
    logic         gt, eq, lt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t q[$];

    always #(CLK_PER/2) clk = ~clk;

    cmp12_minmax_sel u0 (
        .opa_i      (opa),
        .opb_i      (opb),
        .pick_min_i (pmin),
        .res_o      (res),
        .a_gt_o     (gt),
        .a_eq_o     (eq),
        .a_lt_o     (lt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: apply at falling edge, push expectation
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic pm, input string tag);
        exp_t e;
        @(negedge clk);
        opa = a; opb = b; pmin = pm;
        e.a = a; e.b = b; e.pmin = pm; e.tag = tag;
        e.gt = (a > b); e.eq = (a == b); e.lt = (a < b);
        if (pm) e.res = (a < b) ? a : b;
        else    e.res = (a > b) ? a : b;
        q.push_back(e);
    endtask

    // monitor: sample at rising edge, half a period after inputs settle
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                chk(eq == e.eq, {e.tag, " R1 eq"}, int'(eq), int'(e.eq));
                chk(gt == e.gt, {e.tag, " R2 gt"}, int'(gt), int'(e.gt));
                chk(lt == e.lt, {e.tag, " R3 lt"}, int'(lt), int'(e.lt));
                chk($countones({gt, eq, lt}) == 1, {e.tag, " R4 onehot"},
                    int'({gt, eq, lt}), 1);
                if (e.eq)
                    chk(res == e.a, {e.tag, " R7 equal res"}, int'(res), int'(e.a));
                else if (e.pmin)
                    chk(res == e.res, {e.tag, " R5 min"}, int'(res), int'(e.res));
                else
                    chk(res == e.res, {e.tag, " R6 max"}, int'(res), int'(e.res));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state check: zero operands give equal and zero result
        @(posedge clk);
        chk(eq == 1'b1 && gt == 1'b0 && lt == 1'b0, "reset R1 R4", int'({gt, eq, lt}), 3'b010);
        chk(res == '0, "reset R7", int'(res), 0);

        for (int m = 0; m < 2; m++) begin
            drive(12'h000, 12'h000, 1'(m), "zeros R7");
            drive(12'hFFF, 12'hFFF, 1'(m), "ones R7");
            drive(12'hFFF, 12'h000, 1'(m), "ones-zeros");
            drive(12'h000, 12'hFFF, 1'(m), "zeros-ones");
            drive(12'h5A1, 12'h5A0, 1'(m), "lsb R8");
            drive(12'h5A0, 12'h5A1, 1'(m), "lsb R8");
            drive(12'h100, 12'h0FF, 1'(m), "top slice R8");
            drive(12'h0FF, 12'h100, 1'(m), "top slice R8");
            drive(12'h310, 12'h30F, 1'(m), "mid slice R8");
            drive(12'h30F, 12'h310, 1'(m), "mid slice R8");
            drive(12'h800, 12'h7FF, 1'(m), "msb R8");
        end
        for (int i = 0; i < N_RAND; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (i % 7 == 0) ? ra : W'($urandom);
            drive(ra, rb, 1'(i % 2), "random R5 R6");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule